// File: doc/BRIEF.md
# Chainable Pipelined Single-Precision Multiplier

This block multiplies two 32-bit single-precision floating-point numbers in a fixed eight-register pipeline. Each operand comes in on its own port with its own valid flag. The block keeps each operand in a holding register until its partner arrives. When both holding registers are full, the pair is issued into the pipeline. The result leaves with a result-valid flag that travels alongside the data. That flag can feed either operand-valid input of another copy of the block, so several multipliers can be wired into a chain with no central sequencer.

Rounding is round-to-nearest-even. The special cases are handled in a reduced form:
- Subnormal inputs count as zero, and results below the normal range become signed zero.
- Results that are too large become signed infinity.
- Every invalid case yields one canonical quiet NaN.

Nothing downstream can stall the pipeline.

Top module: `fp_chain_mul`

## Requirements
- R1: For two normal finite operands, `res_data` is the sign-magnitude product rounded to nearest, with ties going to an even significand, in IEEE single-precision format (sign bit 31, biased exponent bits 30:23, fraction bits 22:0).
- R2: If both holding registers are full after rising edge k, `res_rdy` is high with that pair's product during exactly the cycle after rising edge k+8. In every other cycle `res_rdy` is low.
- R3: If both ready inputs are held high for N consecutive cycles, N results come out on N consecutive cycles.
- R4: An operand that arrives before its partner stays in its holding register. No result is produced until the partner arrives, and the held value is the one that gets used.
- R5: Issuing a pair empties both holding registers. A ready on the same edge refills its register. A ready on a side whose register is still full replaces the held value.
- R6: An input with a biased exponent of 0 is treated as a zero of the same sign. A normal product whose rounded exponent falls below 1 gives a zero carrying the product's sign.
- R7: A rounded exponent above 254 gives infinity carrying the product's sign. Infinity times a nonzero non-NaN operand also gives that signed infinity.
- R8: Either of these inputs gives 0x7FC00000: a NaN in either input (exponent 255 with a nonzero fraction), or infinity times zero.
- R9: Synchronous reset empties both holding registers and clears every pipeline valid bit. `res_rdy` stays low until a new pair is issued after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lhs_rdy | input | 1 | Left operand valid |
| lhs_data | input | 32 | Left operand |
| rhs_rdy | input | 1 | Right operand valid |
| rhs_data | input | 32 | Right operand |
| res_rdy | output | 1 | Result valid |
| res_data | output | 32 | Product |

## Verification
The assertions check the following on every cycle:
- `res_rdy` tracks the issue history exactly eight cycles back.
- A lone held operand stays unchanged.
- Both holding registers empty together on issue.
- No output is ever a subnormal value or a non-canonical NaN.

Only the bench scenarios can show the following:
- The rounded numeric values, including exact ties.
- That overwrite, early arrival and back-to-back streaming pair the correct operands.
- That reset in the middle of a run discards a half-formed pair.

// File: rtl/fp_chain_mul.sv
module fp_chain_mul #(
  parameter int W = 32,
  parameter int EW = 8,
  parameter int FW = 23,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lhs_rdy,
  input  logic [W-1:0] lhs_data,
  input  logic         rhs_rdy,
  input  logic [W-1:0] rhs_data,
  output logic         res_rdy,
  output logic [W-1:0] res_data
);
  localparam int MW = FW + 1;
  localparam int PW = 2 * MW;
  localparam int XW = EW + 2;
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic signed [XW-1:0] BIAS = XW'((1 << (EW - 1)) - 1);
  localparam logic signed [XW-1:0] ETOP = XW'((1 << EW) - 2);
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}};

  logic         lv, rv;
  logic [W-1:0] lreg, rreg;
  wire          issue = lv & rv;

  always_ff @(posedge clk) begin
    if (rst) lv <= 1'b0;
    else if (lhs_rdy) lv <= 1'b1;
    else if (issue) lv <= 1'b0;
    if (rst) rv <= 1'b0;
    else if (rhs_rdy) rv <= 1'b1;
    else if (issue) rv <= 1'b0;
    if (lhs_rdy) lreg <= lhs_data;
    if (rhs_rdy) rreg <= rhs_data;
  end

  logic [DEPTH:1] v;
  always_ff @(posedge clk) begin
    if (rst) v <= '0;
    else v <= {v[DEPTH-1:1], issue};
  end

  logic [W-1:0] a1, b1;
  always_ff @(posedge clk) begin
    a1 <= lreg;
    b1 <= rreg;
  end

  wire [EW-1:0] ea = a1[W-2:FW];
  wire [EW-1:0] eb = b1[W-2:FW];
  wire za = (ea == '0);
  wire zb = (eb == '0);
  wire xa = (ea == EMAX);
  wire xb = (eb == EMAX);
  wire nana = xa & (|a1[FW-1:0]);
  wire nanb = xb & (|b1[FW-1:0]);
  wire inf_any = xa | xb;
  wire sg1 = a1[W-1] ^ b1[W-1];
  wire bad = nana | nanb | (inf_any & (za | zb));

  logic                 sp2, sg2;
  logic [W-1:0]         spw2;
  logic signed [XW-1:0] e2;
  logic [PW-1:0]        p2;
  always_ff @(posedge clk) begin
    sp2  <= inf_any | za | zb;
    spw2 <= bad ? QNAN : inf_any ? {sg1, EMAX, {FW{1'b0}}} : {sg1, {(W-1){1'b0}}};
    sg2  <= sg1;
    e2   <= $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS;
    p2   <= {1'b1, a1[FW-1:0]} * {1'b1, b1[FW-1:0]};
  end

  wire          hi  = p2[PW-1];
  wire [FW-1:0] mnt = hi ? p2[PW-2:MW] : p2[PW-3:MW-1];
  wire          gd  = hi ? p2[MW-1] : p2[MW-2];
  wire          stk = hi ? |p2[MW-2:0] : |p2[MW-3:0];
  wire [FW:0]   rnd = {1'b0, mnt} + {{FW{1'b0}}, gd & (stk | mnt[0])};
  wire signed [XW-1:0] ef = e2 + $signed({{(XW-1){1'b0}}, hi}) + $signed({{(XW-1){1'b0}}, rnd[FW]});
  wire [W-1:0]  w3 = sp2 ? spw2
                   : (ef > ETOP) ? {sg2, EMAX, {FW{1'b0}}}
                   : (ef < XW'(1)) ? {sg2, {(W-1){1'b0}}}
                   : {sg2, ef[EW-1:0], rnd[FW-1:0]};

  logic [W-1:0] dly [3:DEPTH];
  always_ff @(posedge clk) dly[3] <= w3;
  for (genvar i = 4; i <= DEPTH; i++) begin : g_dly
    always_ff @(posedge clk) dly[i] <= dly[i-1];
  end

  assign res_rdy  = v[DEPTH];
  assign res_data = dly[DEPTH];
endmodule

module fp_chain_mul_chk (
  input logic        clk,
  input logic        rst,
  input logic        lhs_rdy,
  input logic        rhs_rdy,
  input logic        lv,
  input logic        rv,
  input logic [31:0] lreg,
  input logic        res_rdy,
  input logic [31:0] res_data
);
  logic [7:0] hist;
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else hist <= {hist[6:0], lv & rv};
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst) res_rdy == hist[7]);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (lv && !rv && !rhs_rdy && !lhs_rdy) |=> (lv && $stable(lreg)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (lv && rv && !lhs_rdy && !rhs_rdy) |=> (!lv && !rv));

  p_no_denorm_r6: assert property (@(posedge clk) disable iff (rst)
    res_rdy |-> !(res_data[30:23] == 8'h00 && res_data[22:0] != 23'd0));

  p_canon_nan_r8: assert property (@(posedge clk) disable iff (rst)
    (res_rdy && res_data[30:23] == 8'hFF) |-> (res_data[22:0] == 23'd0 || res_data == 32'h7FC00000));

  p_reset_r9: assert property (@(posedge clk) rst |=> (!res_rdy && !lv && !rv));
endmodule

bind fp_chain_mul fp_chain_mul_chk u_chk (
  .clk(clk), .rst(rst), .lhs_rdy(lhs_rdy), .rhs_rdy(rhs_rdy),
  .lv(lv), .rv(rv), .lreg(lreg), .res_rdy(res_rdy), .res_data(res_data)
);

// File: tb/fp_chain_mul_tb.sv
module fp_chain_mul_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lhs_rdy = 1'b0, rhs_rdy = 1'b0;
  logic [31:0] lhs_data = '0, rhs_data = '0;
  logic res_rdy;
  logic [31:0] res_data;

  fp_chain_mul u_dut (
    .clk(clk), .rst(rst), .lhs_rdy(lhs_rdy), .lhs_data(lhs_data),
    .rhs_rdy(rhs_rdy), .rhs_data(rhs_data), .res_rdy(res_rdy), .res_data(res_data)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  string ovr = "";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    int ea, eb, e, sh;
    logic s;
    longint unsigned p, q, rem, half;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return 32'h7FC00000;
    if ((ea == 255 || eb == 255) && (ea == 0 || eb == 0)) return 32'h7FC00000;
    if (ea == 255 || eb == 255) return {s, 8'hFF, 23'd0};
    if (ea == 0 || eb == 0) return {s, 31'd0};
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e = ea + eb - 127;
    sh = (p >> 47) != 0 ? 24 : 23;
    if (sh == 24) e++;
    q = p >> sh;
    rem = p & ((64'd1 << sh) - 1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && q[0])) q++;
    if (q == (64'd1 << 24)) begin q = q >> 1; e++; end
    if (e >= 255) return {s, 8'hFF, 23'd0};
    if (e <= 0) return {s, 31'd0};
    return {s, 8'(e), q[22:0]};
  endfunction

  function automatic string cls(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = ref_mul(a, b);
    if (r == 32'h7FC00000) return "R8";
    if (a[30:23] == 0 || b[30:23] == 0 || r[30:0] == 0) return "R6";
    if (r[30:23] == 8'hFF) return "R7";
    return "R1";
  endfunction

  logic        mlv = 0, mrv = 0;
  logic [31:0] mld, mrd;
  logic [31:0] q_w[$], q_a[$], q_b[$];
  int          q_due[$];
  string       q_tag[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mlv = 0; mrv = 0;
      q_w.delete(); q_a.delete(); q_b.delete(); q_due.delete(); q_tag.delete();
    end else begin
      if (mlv && mrv) begin
        q_w.push_back(ref_mul(mld, mrd));
        q_a.push_back(mld);
        q_b.push_back(mrd);
        q_due.push_back(cyc + 7);
        q_tag.push_back(ovr != "" ? ovr : cls(mld, mrd));
        mlv = 0; mrv = 0;
      end
      if (lhs_rdy) begin mlv = 1; mld = lhs_data; end
      if (rhs_rdy) begin mrv = 1; mrd = rhs_data; end
    end
  end

  int stream_cnt = 0, stream_first = -1, stream_last = -1;
  bit stream_on = 0;

  always @(negedge clk) begin
    bit exp_rdy;
    while (q_due.size() > 0 && q_due[0] < cyc) begin
      void'(q_due.pop_front()); void'(q_w.pop_front()); void'(q_a.pop_front());
      void'(q_b.pop_front()); void'(q_tag.pop_front());
    end
    exp_rdy = (q_due.size() > 0 && q_due[0] == cyc);
    if (!rst) begin
      chk(res_rdy == exp_rdy, "R2", {31'd0, res_rdy}, {31'd0, exp_rdy});
      if (exp_rdy) begin
        chk(res_data === q_w[0], q_tag[0], res_data, q_w[0]);
        void'(q_due.pop_front()); void'(q_w.pop_front()); void'(q_a.pop_front());
        void'(q_b.pop_front()); void'(q_tag.pop_front());
      end
      if (stream_on && res_rdy) begin
        stream_cnt++;
        if (stream_first < 0) stream_first = cyc;
        stream_last = cyc;
      end
    end
  end

  task automatic pair(input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp, input string req);
    @(negedge clk);
    lhs_rdy = 1; rhs_rdy = 1; lhs_data = a; rhs_data = b;
    @(negedge clk);
    lhs_rdy = 0; rhs_rdy = 0;
    repeat (8) @(negedge clk);
    chk(res_rdy === 1'b1 && res_data === exp, req, res_data, exp);
  endtask

  function automatic logic [31:0] rnd_op();
    logic [31:0] x = $urandom;
    case ($urandom % 16)
      0: x[30:23] = 8'hFF;
      1: x[30:23] = 8'h00;
      2: x[30:23] = 8'(200 + $urandom % 56);
      3: x[30:23] = 8'($urandom % 40);
      default: x[30:23] = 8'(100 + $urandom % 55);
    endcase
    return x;
  endfunction

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(res_rdy === 1'b0, "R9", {31'd0, res_rdy}, 32'd0);
    rst = 0;
    @(negedge clk);

    pair(32'h3F800000, 32'h3F800000, 32'h3F800000, "R1");
    pair(32'h40000000, 32'h40400000, 32'h40C00000, "R1");
    pair(32'hBF800000, 32'h3F800000, 32'hBF800000, "R1");
    pair(32'h3FC00000, 32'h3F800001, 32'h3FC00002, "R1");
    pair(32'h3FC00000, 32'h3F800003, 32'h3FC00004, "R1");
    pair(32'h7F000000, 32'h40000000, 32'h7F800000, "R7");
    pair(32'h7F800000, 32'hC0000000, 32'hFF800000, "R7");
    pair(32'h00800000, 32'h3F000000, 32'h00000000, "R6");
    pair(32'h00000001, 32'h3F800000, 32'h00000000, "R6");
    pair(32'h80000000, 32'h3F800000, 32'h80000000, "R6");
    pair(32'h7F800000, 32'h00000000, 32'h7FC00000, "R8");
    pair(32'h7FC12345, 32'h3F800000, 32'h7FC00000, "R8");

    // R4: left waits several cycles for right
    ovr = "R4";
    @(negedge clk); lhs_rdy = 1; lhs_data = 32'h40400000;
    @(negedge clk); lhs_rdy = 0;
    repeat (6) @(negedge clk);
    chk(res_rdy === 1'b0, "R4", {31'd0, res_rdy}, 32'd0);
    rhs_rdy = 1; rhs_data = 32'h40800000;
    @(negedge clk); rhs_rdy = 0;
    repeat (8) @(negedge clk);
    chk(res_rdy === 1'b1 && res_data === 32'h41400000, "R4", res_data, 32'h41400000);

    // R5: second left replaces the first before right arrives
    ovr = "R5";
    @(negedge clk); lhs_rdy = 1; lhs_data = 32'h40000000;
    @(negedge clk); lhs_data = 32'h40A00000;
    @(negedge clk); lhs_rdy = 0; rhs_rdy = 1; rhs_data = 32'h40000000;
    @(negedge clk); rhs_rdy = 0;
    repeat (8) @(negedge clk);
    chk(res_rdy === 1'b1 && res_data === 32'h41200000, "R5", res_data, 32'h41200000);
    ovr = "";

    // R3: back-to-back streaming
    repeat (3) @(negedge clk);
    stream_on = 1;
    for (int i = 0; i < 64; i++) begin
      lhs_rdy = 1; rhs_rdy = 1; lhs_data = rnd_op(); rhs_data = rnd_op();
      @(negedge clk);
    end
    lhs_rdy = 0; rhs_rdy = 0;
    repeat (14) @(negedge clk);
    stream_on = 0;
    chk(stream_cnt == 64 && stream_last - stream_first == 63, "R3", 32'(stream_cnt), 32'd64);

    // R9: reset mid-run drops a half-formed pair
    lhs_rdy = 1; lhs_data = 32'h3F800000;
    @(negedge clk); lhs_rdy = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    rhs_rdy = 1; rhs_data = 32'h3F800000;
    @(negedge clk); rhs_rdy = 0;
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        if (res_rdy) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R9", 32'(seen), 32'd0);
    end
    lhs_rdy = 1; lhs_data = 32'h40000000;
    @(negedge clk); lhs_rdy = 0;
    repeat (10) @(negedge clk);

    // random mix of arrival patterns
    for (int i = 0; i < 4000; i++) begin
      lhs_rdy = ($urandom % 3) != 0;
      rhs_rdy = ($urandom % 3) != 0;
      lhs_data = rnd_op();
      rhs_data = rnd_op();
      @(negedge clk);
    end
    lhs_rdy = 0; rhs_rdy = 0;
    repeat (12) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule